// File: doc/BRIEF.md
# Integer Execute Stage

This block decodes and executes one fixed-width 32-bit integer instruction in a single combinational pass. A surrounding datapath gives it the instruction word together with the two source operand values already read from the register file. The block returns the computed result, the index of the register to write, a write enable and a flag for instructions it does not recognise. The register file itself, instruction fetch, control flow and memory traffic all sit outside this block.

Two encodings are handled. Register-form words carry opcode 0 and pick their operation through a function code in the low six bits. Immediate-form words pick their operation through the opcode and carry a 16-bit constant. Per operation, that constant is sign-extended, zero-extended or moved into the upper half of the word. Arithmetic wraps modulo 2^32 and never traps.

Top module: `exu_core`

## Requirements
- R1: Fields are decoded as opcode = insn[31:26], first source index = insn[25:21], second source index = insn[20:16], register-form destination = insn[15:11], shift amount = insn[10:6], function code = insn[5:0], immediate = insn[15:0]. A legal register-form instruction (opcode 0) drives its destination index from insn[15:11]. A legal immediate-form instruction drives it from insn[20:16].
- R2: Register-form function code 0x20 returns rs + rt and 0x22 returns rs - rt, both wrapping modulo 2^32 without any flag.
- R3: Register-form function codes 0x24, 0x25 and 0x27 return rs AND rt, rs OR rt and NOT (rs OR rt) respectively.
- R4: Register-form function codes 0x00 and 0x02 shift rt left or right by insn[10:6] (0 to 31) and fill the vacated bits with zeros.
- R5: Opcode 0x08 returns rs plus the immediate sign-extended from bit 15, wrapping modulo 2^32.
- R6: Opcode 0x0C returns rs AND the zero-extended immediate, and opcode 0x0D returns rs OR the zero-extended immediate.
- R7: Opcode 0x0A returns 1 when rs, read as a signed value, is less than the sign-extended immediate, and returns 0 otherwise.
- R8: Opcode 0x0F returns the immediate in bits 31:16 with bits 15:0 cleared, regardless of rs.
- R9: Any opcode other than 0x00, 0x08, 0x0A, 0x0C, 0x0D and 0x0F, and any opcode-0 word whose function code is not among 0x00, 0x02, 0x20, 0x22, 0x24, 0x25 and 0x27, raises the illegal flag, clears the write enable, and drives both the result and the destination index to 0. Every legal instruction drives the write enable high and the illegal flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word to execute |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Computed result |
| dst_idx_o | output | 5 | Register index to write |
| wr_en_o | output | 1 | Result should be written to dst_idx_o |
| illegal_o | output | 1 | Instruction word not recognised |

## Verification
The assertions are immediate checks that read the settled combinational values. They assume the instruction and operand inputs hold steady while a result is being observed, and they assume the operation code handed between the sub-blocks is one of the enumerated values. The bench changes inputs only on the falling clock edge and samples a quarter period later. All stimulus comes from whole instruction words assembled by field, so every operation code reaching the execute logic is one the decoder produces. Unrecognised words are covered on both paths: a bad opcode, and a bad function code under opcode 0.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int INSN_W   = 32;
  localparam int IMM_W    = 16;
  localparam int REG_AW   = 5;
  localparam int OPC_W    = 6;
  localparam int FUN_W    = 6;
  localparam int SHAMT_W  = 5;

  // field positions (fixed by the encoding)
  localparam int OPC_LSB  = 26;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;
  localparam int SH_LSB   = 6;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR,
    OP_SLL, OP_SRL, OP_SLT, OP_PASS, OP_NONE
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN, EXT_ZERO, EXT_UPPER
  } ext_mode_e;

  typedef struct packed {
    alu_op_e   op;
    ext_mode_e ext;
    logic      use_imm;
    logic      dst_is_rt;
    logic      legal;
  } ctrl_t;

  // opcode values
  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'h0F;

  // function codes
  localparam logic [FUN_W-1:0] FN_SLL = 6'h00;
  localparam logic [FUN_W-1:0] FN_SRL = 6'h02;
  localparam logic [FUN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUN_W-1:0] FN_AND = 6'h24;
  localparam logic [FUN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUN_W-1:0] FN_NOR = 6'h27;

  localparam ctrl_t CTRL_BAD = '{op: OP_NONE, ext: EXT_ZERO, use_imm: 1'b0,
                                 dst_is_rt: 1'b0, legal: 1'b0};

  function automatic ctrl_t reg_ctrl(alu_op_e op);
    return '{op: op, ext: EXT_ZERO, use_imm: 1'b0, dst_is_rt: 1'b0, legal: 1'b1};
  endfunction

  function automatic ctrl_t imm_ctrl(alu_op_e op, ext_mode_e ext);
    return '{op: op, ext: ext, use_imm: 1'b1, dst_is_rt: 1'b1, legal: 1'b1};
  endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FUN_W-1:0] funct_i,
  output ctrl_t            ctrl_o
);

  ctrl_t reg_form;
  ctrl_t imm_form;

  // register-form operation from the function code
  always_comb begin
    unique case (funct_i)
      FN_ADD:  reg_form = reg_ctrl(OP_ADD);
      FN_SUB:  reg_form = reg_ctrl(OP_SUB);
      FN_AND:  reg_form = reg_ctrl(OP_AND);
      FN_OR:   reg_form = reg_ctrl(OP_OR);
      FN_NOR:  reg_form = reg_ctrl(OP_NOR);
      FN_SLL:  reg_form = reg_ctrl(OP_SLL);
      FN_SRL:  reg_form = reg_ctrl(OP_SRL);
      default: reg_form = CTRL_BAD;
    endcase
  end

  // immediate-form operation and extension mode from the opcode
  always_comb begin
    unique case (opcode_i)
      OPC_ADDI: imm_form = imm_ctrl(OP_ADD,  EXT_SIGN);
      OPC_SLTI: imm_form = imm_ctrl(OP_SLT,  EXT_SIGN);
      OPC_ANDI: imm_form = imm_ctrl(OP_AND,  EXT_ZERO);
      OPC_ORI:  imm_form = imm_ctrl(OP_OR,   EXT_ZERO);
      OPC_LUI:  imm_form = imm_ctrl(OP_PASS, EXT_UPPER);
      default:  imm_form = CTRL_BAD;
    endcase
  end

  assign ctrl_o = (opcode_i == OPC_REG) ? reg_form : imm_form;

  // R9: a legal decode never carries the placeholder operation
  always_comb begin
    // R9
    legal_op_chk: assert (!ctrl_o.legal || ctrl_o.op != OP_NONE)
      else $error("legal decode with no operation");
  end

endmodule

// File: rtl/exu_immext.sv
module exu_immext
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  ext_mode_e         mode_i,
  output logic [DATA_W-1:0] imm_o
);

  localparam int HI_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] as_signed, as_zero, as_upper;

  assign as_signed = {{HI_W{imm_i[IMM_W-1]}}, imm_i};
  assign as_zero   = {{HI_W{1'b0}}, imm_i};
  assign as_upper  = {imm_i, {HI_W{1'b0}}};

  always_comb begin
    unique case (mode_i)
      EXT_SIGN:  imm_o = as_signed;
      EXT_UPPER: imm_o = as_upper;
      default:   imm_o = as_zero;
    endcase
  end

  always_comb begin
    // R5
    sext_fill_chk: assert (mode_i != EXT_SIGN ||
                           imm_o[DATA_W-1:IMM_W-1] == '0 ||
                           imm_o[DATA_W-1:IMM_W-1] == '1)
      else $error("sign extension not uniform");
    // R6
    zext_fill_chk: assert (mode_i != EXT_ZERO || imm_o[DATA_W-1:IMM_W] == '0)
      else $error("zero extension leaked upper bits");
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e            op_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [DATA_W-1:0]  shv_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  y_o
);

  function automatic logic [DATA_W-1:0] f_add(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] f_sub(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
    return x + ~y + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] f_slt(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
    logic lt;
    lt = (x[DATA_W-1] != y[DATA_W-1]) ? x[DATA_W-1] : (x[DATA_W-2:0] < y[DATA_W-2:0]);
    return {{(DATA_W-1){1'b0}}, lt};
  endfunction

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = f_add(a_i, b_i);
      OP_SUB:  y_o = f_sub(a_i, b_i);
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_NOR:  y_o = ~(a_i | b_i);
      OP_SLL:  y_o = shv_i << shamt_i;
      OP_SRL:  y_o = shv_i >> shamt_i;
      OP_SLT:  y_o = f_slt(a_i, b_i);
      OP_PASS: y_o = b_i;
      default: y_o = '0;
    endcase
  end

  logic [DATA_W-1:0] low_mask;
  assign low_mask = (DATA_W'(1) << shamt_i) - DATA_W'(1);

  always_comb begin
    // R3
    nor_disjoint_chk: assert (op_i != OP_NOR || (y_o & (a_i | b_i)) == '0)
      else $error("nor result overlaps operands");
    // R4
    sll_fill_chk: assert (op_i != OP_SLL || (y_o & low_mask) == '0)
      else $error("left shift did not clear low bits");
    // R4
    srl_fill_chk: assert (op_i != OP_SRL || (y_o & ~(~low_mask >> shamt_i) & ~low_mask) == '0
                          || shamt_i == '0)
      else $error("right shift did not clear high bits");
    // R7
    slt_bool_chk: assert (op_i != OP_SLT || y_o[DATA_W-1:1] == '0)
      else $error("compare result not boolean");
  end

endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic [REG_AW-1:0] dst_idx_o,
  output logic              wr_en_o,
  output logic              illegal_o
);

  // named field taps
  logic [OPC_W-1:0]   f_opc;
  logic [REG_AW-1:0]  f_rt, f_rd;
  logic [SHAMT_W-1:0] f_sh;
  logic [FUN_W-1:0]   f_fn;
  logic [IMM_W-1:0]   f_imm;

  assign f_opc = insn_i[OPC_LSB +: OPC_W];
  assign f_rt  = insn_i[RT_LSB  +: REG_AW];
  assign f_rd  = insn_i[RD_LSB  +: REG_AW];
  assign f_sh  = insn_i[SH_LSB  +: SHAMT_W];
  assign f_fn  = insn_i[0 +: FUN_W];
  assign f_imm = insn_i[0 +: IMM_W];

  ctrl_t             ctrl;
  logic [DATA_W-1:0] imm_ext, opnd_b, alu_y;

  exu_decode u_dec (
    .opcode_i (f_opc),
    .funct_i  (f_fn),
    .ctrl_o   (ctrl)
  );

  exu_immext #(.DATA_W(DATA_W)) u_ext (
    .imm_i  (f_imm),
    .mode_i (ctrl.ext),
    .imm_o  (imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : rt_val_i;

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (ctrl.op),
    .a_i     (rs_val_i),
    .b_i     (opnd_b),
    .shv_i   (rt_val_i),
    .shamt_i (f_sh),
    .y_o     (alu_y)
  );

  // events brought out for checking
  logic ev_illegal, ev_lui;
  assign ev_illegal = !ctrl.legal;
  assign ev_lui     = ctrl.legal && ctrl.op == OP_PASS;

  assign illegal_o = ev_illegal;
  assign wr_en_o   = ctrl.legal;
  assign result_o  = ctrl.legal ? alu_y : '0;
  assign dst_idx_o = !ctrl.legal ? '0 : (ctrl.dst_is_rt ? f_rt : f_rd);

  always_comb begin
    // R9
    illegal_quiet_chk: assert (!illegal_o || (!wr_en_o && result_o == '0 && dst_idx_o == '0))
      else $error("illegal word produced a write");
    // R8
    lui_low_chk: assert (!ev_lui || result_o[IMM_W-1:0] == '0)
      else $error("upper-immediate left low bits set");
    // R8
    lui_high_chk: assert (!ev_lui || result_o[DATA_W-1:DATA_W-IMM_W] == f_imm)
      else $error("upper-immediate lost the constant");
    // R1
    dst_field_chk: assert (!wr_en_o || dst_idx_o == f_rd || dst_idx_o == f_rt)
      else $error("destination not from an encoded field");
  end

endmodule

// File: tb/sim_exu_core.sv
module sim_exu_core;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [31:0] insn, rs_v, rt_v;
  logic [31:0] res;
  logic [4:0]  dst;
  logic        we, ill;

  exu_core u0 (
    .insn_i    (insn),
    .rs_val_i  (rs_v),
    .rt_val_i  (rt_v),
    .result_o  (res),
    .dst_idx_o (dst),
    .wr_en_o   (we),
    .illegal_o (ill)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rword(int fn, int rs, int rt, int rd, int sh);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] iword(int opc, int rs, int rt, logic [15:0] k);
    return {6'(opc), 5'(rs), 5'(rt), k};
  endfunction

  // apply on falling edge, look a quarter period later
  task automatic apply(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    insn = w; rs_v = a; rt_v = b;
    #5;
  endtask

  task automatic expect_write(string req, logic [31:0] r, logic [4:0] d);
    check(req, "result", res, r);
    check(req, "dst", {27'd0, dst}, {27'd0, d});
    check(req, "wr_en", {31'd0, we}, 32'd1);
    check(req, "illegal", {31'd0, ill}, 32'd0);
  endtask

  task automatic t_reset;
    wait (!rst);
    #1;
    // all-zero word: shift-left of rt by 0 into register 0 (R1, R4)
    check("R1", "reset dst", {27'd0, dst}, 32'd0);
    check("R4", "reset result", res, 32'd0);
    check("R9", "reset illegal", {31'd0, ill}, 32'd0);
  endtask

  task automatic t_arith;   // R2
    apply(rword(32'h20, 3, 4, 9, 0), 32'd100, 32'd23);
    expect_write("R2", 32'd123, 5'd9);
    apply(rword(32'h20, 3, 4, 9, 0), 32'hFFFF_FFFF, 32'd2);
    expect_write("R2", 32'd1, 5'd9);
    apply(rword(32'h22, 3, 4, 17, 0), 32'd5, 32'd7);
    expect_write("R2", 32'hFFFF_FFFE, 5'd17);
    apply(rword(32'h22, 3, 4, 17, 0), 32'h8000_0000, 32'd1);
    expect_write("R2", 32'h7FFF_FFFF, 5'd17);
  endtask

  task automatic t_logic;   // R3
    apply(rword(32'h24, 1, 2, 5, 0), 32'h0000_0DC0, 32'h0000_3C00);
    expect_write("R3", 32'h0000_0C00, 5'd5);
    apply(rword(32'h25, 1, 2, 5, 0), 32'h0000_0DC0, 32'h0000_3C00);
    expect_write("R3", 32'h0000_3DC0, 5'd5);
    apply(rword(32'h27, 1, 0, 6, 0), 32'h0000_3C00, 32'h0);
    expect_write("R3", 32'hFFFF_C3FF, 5'd6);
  endtask

  task automatic t_shift;   // R4
    for (int s = 0; s < 32; s += 7) begin
      apply(rword(32'h00, 0, 2, 8, s), 32'hDEAD_0000, 32'h8000_0001);
      expect_write("R4", 32'(64'h8000_0001 * (64'd1 << s)), 5'd8);
      apply(rword(32'h02, 0, 2, 8, s), 32'hDEAD_0000, 32'h8000_0001);
      expect_write("R4", 32'h8000_0001 / (32'd1 << s), 5'd8);
    end
    apply(rword(32'h00, 0, 2, 8, 31), 32'h0, 32'hFFFF_FFFF);
    expect_write("R4", 32'h8000_0000, 5'd8);
    apply(rword(32'h02, 0, 2, 8, 31), 32'h0, 32'hFFFF_FFFF);
    expect_write("R4", 32'h1, 5'd8);
  endtask

  task automatic t_addi;    // R5, R1 (rt destination)
    apply(iword(32'h08, 7, 12, 16'd4), 32'd10, 32'hAAAA_AAAA);
    expect_write("R5", 32'd14, 5'd12);
    apply(iword(32'h08, 7, 12, 16'hFFFF), 32'd10, 32'h0);
    expect_write("R5", 32'd9, 5'd12);
    apply(iword(32'h08, 7, 12, 16'h8000), 32'd0, 32'h0);
    expect_write("R1", 32'hFFFF_8000, 5'd12);
  endtask

  task automatic t_logic_imm;  // R6
    apply(iword(32'h0C, 9, 8, 16'hFF00), 32'hFFFF_FFFF, 32'h0);
    expect_write("R6", 32'h0000_FF00, 5'd8);
    apply(iword(32'h0D, 9, 8, 16'hFF00), 32'h1234_0001, 32'h0);
    expect_write("R6", 32'h1234_FF01, 5'd8);
  endtask

  task automatic t_slti;    // R7
    apply(iword(32'h0A, 18, 8, 16'd15), 32'd3, 32'h0);
    expect_write("R7", 32'd1, 5'd8);
    apply(iword(32'h0A, 18, 8, 16'd15), 32'd15, 32'h0);
    expect_write("R7", 32'd0, 5'd8);
    apply(iword(32'h0A, 18, 8, 16'hFFFF), 32'hFFFF_FFFE, 32'h0);
    expect_write("R7", 32'd1, 5'd8);
    apply(iword(32'h0A, 18, 8, 16'hFFFF), 32'h7FFF_FFFF, 32'h0);
    expect_write("R7", 32'd0, 5'd8);
    apply(iword(32'h0A, 18, 8, 16'd0), 32'h8000_0000, 32'h0);
    expect_write("R7", 32'd1, 5'd8);
  endtask

  task automatic t_lui;     // R8
    apply(iword(32'h0F, 0, 8, 16'hAAAA), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    expect_write("R8", 32'hAAAA_0000, 5'd8);
  endtask

  task automatic t_illegal; // R9
    apply(iword(32'h23, 3, 8, 16'd24), 32'd1, 32'd2);
    check("R9", "illegal", {31'd0, ill}, 32'd1);
    check("R9", "wr_en", {31'd0, we}, 32'd0);
    check("R9", "result", res, 32'd0);
    check("R9", "dst", {27'd0, dst}, 32'd0);
    apply(rword(32'h21, 3, 4, 9, 0), 32'd1, 32'd2);
    check("R9", "illegal funct", {31'd0, ill}, 32'd1);
    check("R9", "wr_en funct", {31'd0, we}, 32'd0);
    check("R9", "dst funct", {27'd0, dst}, 32'd0);
  endtask

  initial begin
    insn = '0; rs_v = '0; rt_v = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset;
    t_arith;
    t_logic;
    t_shift;
    t_addi;
    t_logic_imm;
    t_slti;
    t_lui;
    t_illegal;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule